// File: doc/BRIEF.md
# SPI Slave Boot Image Receiver

This block lets an external SPI master load a firmware image into on-chip RAM. It is a mode-0 SPI slave. The master clocks a fixed sequence of byte slots into it. The first slots carry a two-byte preamble, a 16-bit little-endian word count, an expected checksum and a transfer-width code. The slave replies on MISO in set response slots with 0x02 (accept) or 0x20 (reject). After the header, the payload arrives in slots 8, 16 or 32 bits wide. The block packs it into 32-bit words and writes them to consecutive RAM addresses starting at zero. After the payload come two trailing slots. In the second of them the slave reports whether the XOR checksum matched.

The SPI pins are synchronised into the system clock, and all logic runs on that clock. The system clock must therefore be several times faster than SCK. A session starts each time chip select is asserted. Releasing chip select abandons whatever was in progress. A sticky done/error pair reports the outcome to the rest of the chip until the next session starts.

Top module: `spi_boot_rx`

## Requirements
- R1: Bits are sampled on SCK rising edges and shifted most significant bit first. Header slots are 8 bits wide. Every MISO slot that is not a response slot carries zero, and MISO is low while chip select is deasserted.
- R2: The first two slots must carry 0x70 then 0x50. The third slot is ignored. Slot 3 returns 0x02 if both preamble bytes matched and 0x20 otherwise.
- R3: Slots 3 and 4 carry the word count, low byte first. Slot 6 returns 0x02 only if the preamble was accepted and the count lies between 1 and 2^RAM_AW inclusive. Otherwise it returns 0x20.
- R4: Slot 6 carries the width code: 0x00 selects 8-bit, 0x01 selects 16-bit and 0x02 selects 32-bit data slots. Any other value is reserved. Slot 8 is the first data slot and is already of the selected width. In it the slave returns 0x02, right-justified, if every header check passed. Otherwise it returns 0x20 in an 8-bit slot.
- R5: After any rejection, every later response slot of the session returns 0x20 and no RAM write occurs. Done and error both go high once the slot-8 response is decided.
- R6: The payload occupies count×4, count×2 or count slots for widths 8, 16 and 32. Within a word, the least significant part is transferred first. Each completed word is written once, to addresses 0, 1, 2 … in order.
- R7: Slot 5 carries the expected checksum: 0xFF XORed with every payload byte. Two slots of the data width follow the payload. The first returns zero. The second returns 0x02 if the computed checksum equals the expected one and 0x20 otherwise.
- R8: Done and error are cleared when chip select is asserted. When the final response is decided, done is set and error is set to the checksum mismatch. Error never stands without done, and the status holds until the next chip-select assertion.
- R9: Deasserting chip select at any point abandons the session. The next assertion starts again at the preamble slot, at RAM address 0.
- R10: After reset, done, error, the RAM write enable and MISO are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the master, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial response to the master |
| ram_we | output | 1 | RAM word write strobe |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| boot_done | output | 1 | Session has reached its final status |
| boot_err | output | 1 | Final status was a rejection |

## Verification
The hardest case to reach from the ports is a session dropped part-way through the payload. In that case the partial word, the write address and the running checksum must all be discarded, with no leftover state. The bench gets there by sending a valid 32-bit-mode header and one payload word, then releasing chip select. It then runs a complete session with a different image. Any write that does not land at address 0, 1, 2 … in order, or a wrong final checksum response, exposes state left over from the dropped session. The header rejection paths are reached by corrupting one header field at a time. Reserved width codes and word counts of zero and one past the RAM depth are covered this way.

// File: rtl/spi_boot_pkg.sv
// Shared constants and types for the SPI boot image receiver.
// Assumes: byte-oriented header, responses are 8-bit codes zero-extended into the current slot width.
package spi_boot_pkg;

    localparam logic [7:0] PREAMBLE_A = 8'h70;
    localparam logic [7:0] PREAMBLE_B = 8'h50;
    localparam logic [7:0] RESP_ACK   = 8'h02;
    localparam logic [7:0] RESP_NACK  = 8'h20;
    localparam int         HDR_SLOTS  = 8;

    // Slot width selection; encoding equals the width code byte received in slot 6.
    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2
    } slot_width_e;

    // Session phase of the protocol controller.
    typedef enum logic [2:0] {
        PH_HEADER,
        PH_PAYLOAD,
        PH_TRAIL_A,
        PH_TRAIL_B,
        PH_QUIET
    } phase_e;

endpackage

// File: rtl/spi_boot_link.sv
// Bit-level SPI mode-0 front end.
// Synchronises SCK, CS_n and MOSI into clk, detects SCK edges, assembles
// frames of 8/16/32 bits, and shifts a response word out MSB first.
// Assumes: clk is at least ~8x faster than SCK; SYNC_STAGES >= 2.
module spi_boot_link
    import spi_boot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  slot_width_e slot_width,
    input  logic        tx_load,
    input  logic [31:0] tx_word,
    output logic        sess_start,
    output logic        frame_done,
    output logic [31:0] frame_val
);

    localparam int CNT_W = 6;

    logic [SYNC_STAGES-1:0] sck_sync;
    logic [SYNC_STAGES-1:0] cs_sync;
    logic [SYNC_STAGES-1:0] mosi_sync;
    logic                   sck_prev;
    logic                   sel_prev;
    logic [CNT_W-1:0]       bit_cnt;
    logic [CNT_W-1:0]       frame_bits;
    logic [31:0]            rx_sr;
    logic [31:0]            tx_sr;
    logic [31:0]            rx_next;
    logic [31:0]            val_mask;
    logic                   selected;
    logic                   sck_now;
    logic                   mosi_now;
    logic                   sck_rise;
    logic                   sck_fall;
    logic                   last_bit;

    // Bring the asynchronous pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sync  <= '0;
            cs_sync   <= '1;
            mosi_sync <= '0;
            sck_prev  <= 1'b0;
            sel_prev  <= 1'b0;
        end else begin
            sck_sync  <= {sck_sync[SYNC_STAGES-2:0], spi_sck};
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], spi_cs_n};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], spi_mosi};
            sck_prev  <= sck_now;
            sel_prev  <= selected;
        end
    end

    // Decode synchronised levels into edge events.
    always_comb begin
        sck_now    = sck_sync[SYNC_STAGES-1];
        mosi_now   = mosi_sync[SYNC_STAGES-1];
        selected   = !cs_sync[SYNC_STAGES-1];
        sck_rise   = selected && sck_now && !sck_prev;
        sck_fall   = selected && !sck_now && sck_prev;
        sess_start = selected && !sel_prev;
        case (slot_width)
            WID_16:  frame_bits = CNT_W'(16);
            WID_32:  frame_bits = CNT_W'(32);
            default: frame_bits = CNT_W'(8);
        endcase
        last_bit = (bit_cnt == frame_bits - CNT_W'(1));
        rx_next  = {rx_sr[30:0], mosi_now};
        val_mask = (frame_bits == CNT_W'(32)) ? '1 : ((32'd1 << frame_bits) - 32'd1);
    end

    // Count received bits within a frame and capture the completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sr      <= '0;
            frame_done <= 1'b0;
            frame_val  <= '0;
        end else begin
            frame_done <= 1'b0;
            if (!selected) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sr <= rx_next;
                if (last_bit) begin
                    bit_cnt    <= '0;
                    frame_done <= 1'b1;
                    frame_val  <= rx_next & val_mask;
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    // Hold the response left-aligned and advance it on falling SCK inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (!selected) begin
            tx_sr <= '0;
        end else if (tx_load) begin
            tx_sr <= tx_word << (CNT_W'(32) - frame_bits);
        end else if (sck_fall && (bit_cnt != '0)) begin
            tx_sr <= {tx_sr[30:0], 1'b0};
        end
    end

    assign spi_miso = selected & tx_sr[31];

endmodule

// File: rtl/spi_boot_ctrl.sv
// Slot-level protocol controller.
// Walks the header slots, validates preamble, word count and width code,
// counts payload slots and chooses each MISO response; keeps the status.
// Assumes: one frame_done pulse per completed slot; sess_start precedes a session.
module spi_boot_ctrl
    import spi_boot_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sess_start,
    input  logic               frame_done,
    input  logic [31:0]        frame_val,
    input  logic [7:0]         crc_calc,
    output slot_width_e        slot_width,
    output logic               tx_load,
    output logic [31:0]        tx_word,
    output logic               pay_en,
    output logic               boot_done,
    output logic               boot_err
);

    localparam int DEPTH   = 1 << RAM_AW;
    localparam int SLOT_CW = RAM_AW + 3;

    phase_e               phase;
    logic [2:0]           hdr_idx;
    logic                 rejected;
    logic [15:0]          word_count;
    logic [7:0]           crc_expect;
    slot_width_e          width_req;
    logic                 width_ok;
    logic [SLOT_CW-1:0]   slots_left;
    logic [SLOT_CW-1:0]   slots_total;
    logic [7:0]           rx_byte;
    logic                 count_ok;

    // Derive header checks and the payload slot total.
    always_comb begin
        rx_byte     = frame_val[7:0];
        count_ok    = (word_count != 16'd0) && ({1'b0, word_count} <= 17'(DEPTH));
        slots_total = {word_count[RAM_AW:0], 2'b00} >> width_req;
        pay_en      = frame_done && (phase == PH_PAYLOAD);
    end

    // Advance the session on each completed slot and pick the next response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_QUIET;
            hdr_idx    <= '0;
            rejected   <= 1'b0;
            word_count <= '0;
            crc_expect <= '0;
            width_req  <= WID_8;
            width_ok   <= 1'b0;
            slots_left <= '0;
            slot_width <= WID_8;
            tx_load    <= 1'b0;
            tx_word    <= '0;
            boot_done  <= 1'b0;
            boot_err   <= 1'b0;
        end else if (sess_start) begin
            phase      <= PH_HEADER;
            hdr_idx    <= '0;
            rejected   <= 1'b0;
            width_req  <= WID_8;
            width_ok   <= 1'b0;
            slot_width <= WID_8;
            tx_load    <= 1'b0;
            tx_word    <= '0;
            boot_done  <= 1'b0;
            boot_err   <= 1'b0;
        end else begin
            tx_load <= frame_done;
            if (frame_done) begin
                tx_word <= '0;
                case (phase)
                    PH_HEADER: begin
                        hdr_idx <= hdr_idx + 3'd1;
                        case (hdr_idx)
                            3'd0: if (rx_byte != PREAMBLE_A) rejected <= 1'b1;
                            3'd1: if (rx_byte != PREAMBLE_B) rejected <= 1'b1;
                            3'd2: tx_word <= {24'd0, rejected ? RESP_NACK : RESP_ACK};
                            3'd3: word_count[7:0]  <= rx_byte;
                            3'd4: word_count[15:8] <= rx_byte;
                            3'd5: begin
                                crc_expect <= rx_byte;
                                tx_word    <= {24'd0, (rejected || !count_ok) ? RESP_NACK : RESP_ACK};
                                if (!count_ok) rejected <= 1'b1;
                            end
                            3'd6: begin
                                width_ok  <= (rx_byte <= 8'd2);
                                width_req <= (rx_byte <= 8'd2) ? slot_width_e'(rx_byte[1:0]) : WID_8;
                            end
                            default: begin
                                if (rejected || !width_ok) begin
                                    tx_word   <= {24'd0, RESP_NACK};
                                    phase     <= PH_QUIET;
                                    boot_done <= 1'b1;
                                    boot_err  <= 1'b1;
                                end else begin
                                    tx_word    <= {24'd0, RESP_ACK};
                                    slot_width <= width_req;
                                    slots_left <= slots_total;
                                    phase      <= PH_PAYLOAD;
                                end
                            end
                        endcase
                    end
                    PH_PAYLOAD: begin
                        slots_left <= slots_left - SLOT_CW'(1);
                        if (slots_left == SLOT_CW'(1)) phase <= PH_TRAIL_A;
                    end
                    PH_TRAIL_A: begin
                        tx_word   <= {24'd0, (crc_calc == crc_expect) ? RESP_ACK : RESP_NACK};
                        boot_done <= 1'b1;
                        boot_err  <= (crc_calc != crc_expect);
                        phase     <= PH_TRAIL_B;
                    end
                    PH_TRAIL_B: phase <= PH_QUIET;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_boot_pack.sv
// Payload packer.
// Merges 8/16/32-bit slot values into 32-bit words (low part first),
// writes each full word to the next RAM address and keeps the XOR checksum.
// Assumes: clr pulses at session start; data slots are aligned to the width.
module spi_boot_pack
    import spi_boot_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pay_en,
    input  logic [31:0]       pay_val,
    input  slot_width_e       slot_width,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [31:0]       ram_wdata,
    output logic [7:0]        crc_calc
);

    logic [31:0]       acc;
    logic [1:0]        offset;
    logic [RAM_AW-1:0] next_addr;
    logic [31:0]       merged;
    logic [7:0]        slot_xor;
    logic              word_full;
    int                nbytes;
    int                off_i;

    // Place the slot bytes above the bytes already held and fold them into the checksum.
    always_comb begin
        case (slot_width)
            WID_16:  nbytes = 2;
            WID_32:  nbytes = 4;
            default: nbytes = 1;
        endcase
        off_i    = int'(offset);
        merged   = acc;
        slot_xor = 8'h00;
        for (int i = 0; i < 4; i++) begin
            if (i >= off_i && i < off_i + nbytes) merged[8*i +: 8] = pay_val[8*(i - off_i) +: 8];
            if (i < nbytes) slot_xor = slot_xor ^ pay_val[8*i +: 8];
        end
        word_full = (off_i + nbytes >= 4);
    end

    // Accumulate payload and issue one RAM write per completed word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc       <= '0;
            offset    <= '0;
            next_addr <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
            crc_calc  <= 8'hFF;
        end else begin
            ram_we <= 1'b0;
            if (pay_en) begin
                crc_calc <= crc_calc ^ slot_xor;
                if (word_full) begin
                    ram_we    <= 1'b1;
                    ram_addr  <= next_addr;
                    ram_wdata <= merged;
                    next_addr <= next_addr + RAM_AW'(1);
                    acc       <= '0;
                    offset    <= '0;
                end else begin
                    acc    <= merged;
                    offset <= offset + 2'(nbytes);
                end
            end
        end
    end

endmodule

// File: rtl/spi_boot_rx.sv
// SPI slave boot image receiver, top level.
// Joins the SPI front end, the slot protocol controller and the word packer.
// Assumes: clk well above SCK; RAM accepts one word write per clk.
module spi_boot_rx
    import spi_boot_pkg::*;
#(
    parameter int RAM_AW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [31:0]       ram_wdata,
    output logic              boot_done,
    output logic              boot_err
);

    slot_width_e slot_width;
    logic        tx_load;
    logic [31:0] tx_word;
    logic        sess_start;
    logic        frame_done;
    logic [31:0] frame_val;
    logic        pay_en;
    logic [7:0]  crc_calc;

    spi_boot_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (spi_sck),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .slot_width (slot_width),
        .tx_load    (tx_load),
        .tx_word    (tx_word),
        .sess_start (sess_start),
        .frame_done (frame_done),
        .frame_val  (frame_val)
    );

    spi_boot_ctrl #(.RAM_AW(RAM_AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sess_start (sess_start),
        .frame_done (frame_done),
        .frame_val  (frame_val),
        .crc_calc   (crc_calc),
        .slot_width (slot_width),
        .tx_load    (tx_load),
        .tx_word    (tx_word),
        .pay_en     (pay_en),
        .boot_done  (boot_done),
        .boot_err   (boot_err)
    );

    spi_boot_pack #(.RAM_AW(RAM_AW)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (sess_start),
        .pay_en     (pay_en),
        .pay_val    (frame_val),
        .slot_width (slot_width),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .crc_calc   (crc_calc)
    );

endmodule

// File: rtl/spi_boot_rx_chk.sv
// Port-level checker for spi_boot_rx, attached by bind.
// Assumes: chip select is held high for several clk cycles between sessions.
module spi_boot_rx_chk #(
    parameter int RAM_AW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              boot_done,
    input logic              boot_err
);

    logic [7:0]        cs_hi_cnt;
    logic              wr_seen;
    logic [RAM_AW-1:0] last_addr;

    // Count clk cycles with chip select released, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)             cs_hi_cnt <= '0;
        else if (!spi_cs_n)     cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 8'hFF) cs_hi_cnt <= cs_hi_cnt + 8'd1;
    end

    // Remember the previous write address within a session.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen   <= 1'b0;
            last_addr <= '0;
        end else if (int'(cs_hi_cnt) > SYNC_STAGES + 4) begin
            wr_seen <= 1'b0;
        end else if (ram_we) begin
            wr_seen   <= 1'b1;
            last_addr <= ram_addr;
        end
    end

    // R1: MISO is quiet once the released chip select has crossed the synchroniser.
    p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cs_hi_cnt) > SYNC_STAGES) |-> !spi_miso);

    // R6: successive writes in a session go to successive addresses.
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && wr_seen) |-> (ram_addr == last_addr + RAM_AW'(1)));

    // R5: no RAM write once a final status has been reported.
    p_no_write_after_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> !ram_we);

    // R8: an error is only ever reported together with done.
    p_err_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> boot_done);

    // R8: status is only withdrawn while chip select is asserted (new session).
    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boot_done) |-> !spi_cs_n);

endmodule

bind spi_boot_rx spi_boot_rx_chk #(.RAM_AW(RAM_AW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .boot_done (boot_done),
    .boot_err  (boot_err)
);

// File: tb/spi_boot_rx_tb.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps widths and word counts, then header faults,
// checksum fault and aborted sessions, all against arithmetic expectations.
module spi_boot_rx_tb;

    localparam int RAM_AW = 4;
    localparam int DEPTH  = 1 << RAM_AW;
    localparam int HALF   = 32;
    localparam logic [7:0] ACK  = 8'h02;
    localparam logic [7:0] NACK = 8'h20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spi_sck = 1'b0;
    logic              spi_cs_n = 1'b1;
    logic              spi_mosi = 1'b0;
    logic              spi_miso;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [31:0]       ram_wdata;
    logic              boot_done;
    logic              boot_err;

    int          tests = 0;
    int          fails = 0;
    int          wr_cnt = 0;
    bit          order_err = 0;
    logic [31:0] mem [DEPTH];

    spi_boot_rx #(.RAM_AW(RAM_AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .boot_done(boot_done),
        .boot_err(boot_err)
    );

    always #2.5 clk = ~clk;

    // RAM model: records writes and their order.
    always @(posedge clk) begin
        if (ram_we) begin
            if (int'(ram_addr) != wr_cnt) order_err = 1'b1;
            mem[ram_addr] <= ram_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int seed, input int k);
        return (32'h9E37_79B9 * 32'(k + 1 + seed)) ^ {8'(seed), 24'h00A5C3};
    endfunction

    // One SPI frame, MSB first, mode 0; miso sampled just before each rising edge.
    task automatic spi_frame(input int nbits, input logic [31:0] tx, output logic [31:0] rx);
        rx = '0;
        for (int b = nbits - 1; b >= 0; b--) begin
            spi_mosi = tx[b];
            #(HALF);
            rx = {rx[30:0], spi_miso};
            spi_sck = 1'b1;
            #(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic run_session(input logic [7:0] p0, input logic [7:0] p1, input int len,
                               input logic [7:0] mode_b, input bit crc_bad, input int seed);
        logic [31:0] r;
        logic [7:0]  crc;
        logic [7:0]  hb [8];
        logic [15:0] lv;
        bit          pre_ok, len_ok, mode_ok;
        int          w, per, zero_bad;
        logic [31:0] msk, wd;

        pre_ok  = (p0 == 8'h70) && (p1 == 8'h50);
        len_ok  = (len >= 1) && (len <= DEPTH);
        mode_ok = (mode_b <= 8'd2);
        lv      = 16'(len);
        crc     = 8'hFF;
        for (int k = 0; k < len && k < DEPTH; k++) begin
            wd  = word_of(seed, k);
            crc = crc ^ wd[7:0] ^ wd[15:8] ^ wd[23:16] ^ wd[31:24];
        end
        if (crc_bad) crc = crc ^ 8'h5A;
        hb = '{p0, p1, 8'h00, lv[7:0], lv[15:8], crc, mode_b, 8'h00};
        zero_bad  = 0;
        wr_cnt    = 0;
        order_err = 1'b0;
        for (int k = 0; k < DEPTH; k++) mem[k] = 32'hDEAD_BEEF;

        spi_cs_n = 1'b0;
        #(HALF);
        chk(!boot_done && !boot_err, "R8", "status clear at session start", {boot_done, boot_err}, 0);

        for (int s = 0; s < 8; s++) begin
            spi_frame(8, {24'd0, hb[s]}, r);
            if (s == 3)      chk(r == {24'd0, pre_ok ? ACK : NACK}, "R2", "preamble response", r, pre_ok ? ACK : NACK);
            else if (s == 6) chk(r == {24'd0, (pre_ok && len_ok) ? ACK : NACK}, "R3", "length response", r, (pre_ok && len_ok) ? ACK : NACK);
            else if (r != 0) zero_bad++;
        end

        if (!(pre_ok && len_ok && mode_ok)) begin
            spi_frame(8, 32'h0, r);
            chk(r == {24'd0, NACK}, "R4", "slot 8 reject", r, NACK);
            chk(boot_done && boot_err, "R5", "reject status", {boot_done, boot_err}, 2'b11);
            spi_frame(8, 32'hFF, r);
            spi_cs_n = 1'b1;
            #(4 * HALF);
            chk(wr_cnt == 0, "R5", "no writes after reject", wr_cnt, 0);
        end else begin
            w   = 8 << mode_b;
            per = 32 / w;
            msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
            for (int k = 0; k < len; k++) begin
                for (int s = 0; s < per; s++) begin
                    spi_frame(w, (word_of(seed, k) >> (w * s)) & msk, r);
                    if (k == 0 && s == 0) chk(r == {24'd0, ACK}, "R4", "slot 8 accept", r, ACK);
                    else if (r != 0) zero_bad++;
                end
            end
            chk(!boot_done, "R8", "no status before trailing slots", boot_done, 0);
            spi_frame(w, 32'h0, r);
            if (r != 0) zero_bad++;
            spi_frame(w, 32'h0, r);
            chk(r == {24'd0, crc_bad ? NACK : ACK}, "R7", "final checksum response", r, crc_bad ? NACK : ACK);
            spi_cs_n = 1'b1;
            #(4 * HALF);
            chk(boot_done && (boot_err == crc_bad), "R8", "final status", {boot_done, boot_err}, {1'b1, crc_bad});
            chk(wr_cnt == len, "R6", "write count", wr_cnt, len);
            chk(!order_err, "R6", "write address order", order_err, 0);
            for (int k = 0; k < len; k++)
                chk(mem[k] == word_of(seed, k), "R6", "RAM word", mem[k], word_of(seed, k));
        end
        chk(zero_bad == 0, "R1", "non-response slots zero", zero_bad, 0);
        chk(spi_miso == 1'b0, "R1", "miso low with CS released", spi_miso, 0);
        #(4 * HALF);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        #50;
        chk(!boot_done && !boot_err && !ram_we && !spi_miso, "R10", "reset state",
            {boot_done, boot_err, ram_we, spi_miso}, 0);
        rst_n = 1'b1;
        #100;
        chk(!boot_done && !boot_err && !ram_we && !spi_miso, "R10", "idle after reset",
            {boot_done, boot_err, ram_we, spi_miso}, 0);

        // Width x length sweep with correct checksums (R4, R6, R7).
        for (int m = 0; m < 3; m++) begin
            run_session(8'h70, 8'h50, 1, 8'(m), 1'b0, m * 7 + 1);
            run_session(8'h70, 8'h50, 3, 8'(m), 1'b0, m * 7 + 2);
            run_session(8'h70, 8'h50, DEPTH, 8'(m), 1'b0, m * 7 + 3);
        end
        // R7: checksum mismatch.
        run_session(8'h70, 8'h50, 2, 8'd1, 1'b1, 40);
        // R2/R5: bad preamble bytes.
        run_session(8'h71, 8'h50, 2, 8'd0, 1'b0, 41);
        run_session(8'h70, 8'h05, 2, 8'd0, 1'b0, 42);
        // R4/R5: reserved width codes.
        run_session(8'h70, 8'h50, 2, 8'd3, 1'b0, 43);
        run_session(8'h70, 8'h50, 2, 8'h80, 1'b0, 44);
        // R3/R5: word count out of range.
        run_session(8'h70, 8'h50, 0, 8'd0, 1'b0, 45);
        run_session(8'h70, 8'h50, DEPTH + 1, 8'd2, 1'b0, 46);

        // R9: abort mid-header inside a partial frame, then a clean session.
        spi_cs_n = 1'b0;
        #(HALF);
        spi_frame(8, 32'h70, r);
        spi_frame(5, 32'h0A, r);
        spi_cs_n = 1'b1;
        #(4 * HALF);
        run_session(8'h70, 8'h50, 2, 8'd0, 1'b0, 50);

        // R9: abort after one payload word, then a clean session from address 0.
        spi_cs_n = 1'b0;
        #(HALF);
        spi_frame(8, 32'h70, r);
        spi_frame(8, 32'h50, r);
        spi_frame(8, 32'h00, r);
        spi_frame(8, 32'h03, r);
        spi_frame(8, 32'h00, r);
        spi_frame(8, 32'h11, r);
        spi_frame(8, 32'h02, r);
        spi_frame(8, 32'h00, r);
        spi_frame(32, 32'hCAFE_F00D, r);
        spi_cs_n = 1'b1;
        #(4 * HALF);
        chk(!boot_done, "R9", "aborted session reports no status", boot_done, 0);
        run_session(8'h70, 8'h50, 4, 8'd2, 1'b0, 51);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule